// File: doc/BRIEF.md
# Descriptor-Table Scatter-Gather DMA Walker

The walker sits between a disk controller's byte buffer and host memory. Software leaves a table of 8-byte region descriptors in host memory and gives the walker the table's base address, the number of bytes the current disk command needs and the transfer direction. After a start pulse the walker reads descriptors one at a time. For each region it issues data-segment requests on a simple request/acknowledge memory port, and each segment is cut so that it never crosses the end of a region or goes past the command's byte count.

A table ends at a descriptor whose control word has its top bit set. A table with no such flag still ends once the walker has read one 4 KiB page of descriptors. If the regions hold more bytes than the command needs, the walker reads the rest of the table and consumes it without moving data, then signals completion. If the table ends before the command is satisfied, the walker signals an underrun. A cancel pulse abandons the walk at any point.

Top module: `prd_walker`

## Requirements
- R1: After reset `busy`, `mem_req`, `done`, `underrun` and `guard_stop` are all low.
- R2: A descriptor fetch is a request with `mem_desc`=1, `mem_we`=0 and `mem_len`=8, made at the descriptor pointer. The pointer is loaded from `table_base` when a run starts and grows by 8 with each acknowledged fetch. The word returned on `mem_rdata` holds the region base in bits 31:0 and the control word in bits 63:32.
- R3: The region length is control bits 15:0 with bit 0 forced to zero. A length that comes out as zero means 65536 bytes.
- R4: Control bit 31 set marks the final descriptor. No descriptor is fetched after it.
- R5: A descriptor is fetched only when the current region has no bytes left.
- R6: Each data request (`mem_desc`=0) covers the smaller of the bytes the command still needs and the bytes left in the region. It starts at the region's current address and carries `mem_we` equal to the `dir_to_host` value sampled at start. The region address then advances by the segment size and the region length drops by the same amount.
- R7: Once the command's byte count has been met, no further data request is made. Region bytes still left are consumed, the remaining descriptors are fetched up to the end of the table, and then `done` pulses.
- R8: Once the pointer is 4096 or more bytes past the table base, fetching stops even without a final flag. `guard_stop` then stays high until the next start.
- R9: If the table ends while the command still needs bytes, `underrun` pulses and `done` does not.
- R10: A request that has not been acknowledged keeps address, length, kind and direction unchanged on the next cycle.
- R11: A cancel while busy returns the walker to idle on the next cycle, drops the request and produces neither `done` nor `underrun`.
- R12: A start while idle makes `busy` high on the next cycle. A start while busy has no effect on the walk.
- R13: `done` and `underrun` are single-cycle pulses, never high together, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| cancel | input | 1 | Abandon the current walk |
| dir_to_host | input | 1 | 1: data goes to host memory, 0: data comes from host memory |
| table_base | input | 32 | Host address of the descriptor table |
| byte_limit | input | 32 | Bytes the current command needs |
| mem_req | output | 1 | Memory request valid |
| mem_desc | output | 1 | 1: descriptor fetch, 0: data segment |
| mem_we | output | 1 | Data segment writes host memory |
| mem_addr | output | 32 | Request start address |
| mem_len | output | 17 | Request length in bytes |
| mem_ack | input | 1 | Request accepted (and fetch data valid) |
| mem_rdata | input | 64 | Descriptor word returned with a fetch acknowledge |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Pulse: walk finished with the command satisfied |
| underrun | output | 1 | Pulse: table ended with bytes still needed |
| guard_stop | output | 1 | The last walk was ended by the one-page guard |

## Verification
After a start pulse, `busy` is high at the next edge. The first fetch request appears one cycle later, because a planning cycle comes before every request. After each acknowledge the next request or the result pulse follows two edges later: one edge to absorb the acknowledge and one to plan. The bench drives inputs and samples outputs on the falling edge. Each cycle it compares any visible request with the head of a queue of requests predicted by its own model, and checks the kind of result and the guard flag on the cycle the pulse is seen.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLAN  = 2'd1,
        ST_FETCH = 2'd2,
        ST_MOVE  = 2'd3
    } walk_st_e;

    // control-word field positions inside the upper half of a descriptor
    localparam int CTL_LEN_W  = 16;
    localparam int CTL_LAST_B = 31;

endpackage

// File: rtl/prd_desc_decode.sv
module prd_desc_decode #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 17
) (
    input  logic [2*ADDR_W-1:0] word,
    output logic [ADDR_W-1:0]   region_base,
    output logic [LEN_W-1:0]    region_len,
    output logic                region_last
);
    import prd_walk_pkg::*;

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(1) << CTL_LEN_W;

    logic [ADDR_W-1:0]    ctl;
    logic [CTL_LEN_W-1:0] even_len;
    logic                 unused_ctl;

    assign ctl          = word[2*ADDR_W-1:ADDR_W];
    assign region_base  = word[ADDR_W-1:0];
    assign even_len     = {ctl[CTL_LEN_W-1:1], 1'b0};
    assign region_len   = (even_len == '0) ? FULL_LEN : LEN_W'(even_len);
    assign region_last  = ctl[CTL_LAST_B];
    assign unused_ctl   = ^ctl[CTL_LAST_B-1:CTL_LEN_W];

endmodule

// File: rtl/prd_seg_size.sv
module prd_seg_size #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 17
) (
    input  logic [CNT_W-1:0] need,
    input  logic [LEN_W-1:0] left,
    output logic [LEN_W-1:0] seg,
    output logic             need_zero,
    output logic             left_zero
);
    logic need_smaller;

    assign need_smaller = need < CNT_W'(left);
    assign seg          = need_smaller ? need[LEN_W-1:0] : left;
    assign need_zero    = (need == '0);
    assign left_zero    = (left == '0);

endmodule

// File: rtl/prd_table_guard.sv
module prd_table_guard #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] base,
    output logic              exhausted
);
    logic [ADDR_W-1:0] span;

    assign span      = ptr - base;
    assign exhausted = span >= ADDR_W'(PAGE_BYTES);

endmodule

// File: rtl/prd_walker.sv
module prd_walker #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 32,
    parameter int LEN_W      = 17,
    parameter int DESC_BYTES = 8,
    parameter int PAGE_BYTES = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cancel,
    input  logic                dir_to_host,
    input  logic [ADDR_W-1:0]   table_base,
    input  logic [CNT_W-1:0]    byte_limit,
    output logic                mem_req,
    output logic                mem_desc,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [LEN_W-1:0]    mem_len,
    input  logic                mem_ack,
    input  logic [2*ADDR_W-1:0] mem_rdata,
    output logic                busy,
    output logic                done,
    output logic                underrun,
    output logic                guard_stop
);
    import prd_walk_pkg::*;

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] cur_addr;
        logic [LEN_W-1:0]  cur_left;
        logic              last;
        logic [CNT_W-1:0]  need;
        logic [LEN_W-1:0]  seg;
        logic              we;
        logic              done;
        logic              under;
        logic              guard;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [ADDR_W-1:0] dec_base;
    logic [LEN_W-1:0]  dec_len;
    logic              dec_last;
    logic [LEN_W-1:0]  seg_c;
    logic              need_zero;
    logic              left_zero;
    logic              table_exhausted;
    logic              table_ended;

    prd_desc_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
        .word        (mem_rdata),
        .region_base (dec_base),
        .region_len  (dec_len),
        .region_last (dec_last)
    );

    prd_seg_size #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_seg (
        .need      (r_q.need),
        .left      (r_q.cur_left),
        .seg       (seg_c),
        .need_zero (need_zero),
        .left_zero (left_zero)
    );

    prd_table_guard #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_guard (
        .ptr       (r_q.ptr),
        .base      (r_q.base),
        .exhausted (table_exhausted)
    );

    assign table_ended = r_q.last || table_exhausted;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.under = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st       = ST_PLAN;
                    r_d.base     = table_base;
                    r_d.ptr      = table_base;
                    r_d.cur_addr = '0;
                    r_d.cur_left = '0;
                    r_d.last     = 1'b0;
                    r_d.need     = byte_limit;
                    r_d.we       = dir_to_host;
                    r_d.guard    = 1'b0;
                end
            end
            ST_PLAN: begin
                if (need_zero) begin
                    if (!left_zero) begin
                        // surplus region bytes are consumed without a transfer
                        r_d.cur_addr = r_q.cur_addr + ADDR_W'(r_q.cur_left);
                        r_d.cur_left = '0;
                    end else if (table_ended) begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.guard = !r_q.last;
                    end else begin
                        r_d.st = ST_FETCH;
                    end
                end else if (!left_zero) begin
                    r_d.seg = seg_c;
                    r_d.st  = ST_MOVE;
                end else if (table_ended) begin
                    r_d.st    = ST_IDLE;
                    r_d.under = 1'b1;
                    r_d.guard = !r_q.last;
                end else begin
                    r_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    r_d.cur_addr = dec_base;
                    r_d.cur_left = dec_len;
                    r_d.last     = dec_last;
                    r_d.ptr      = r_q.ptr + ADDR_W'(DESC_BYTES);
                    r_d.st       = ST_PLAN;
                end
            end
            ST_MOVE: begin
                if (mem_ack) begin
                    r_d.cur_addr = r_q.cur_addr + ADDR_W'(r_q.seg);
                    r_d.cur_left = r_q.cur_left - r_q.seg;
                    r_d.need     = r_q.need - CNT_W'(r_q.seg);
                    r_d.st       = ST_PLAN;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (cancel && (r_q.st != ST_IDLE)) begin
            r_d.st    = ST_IDLE;
            r_d.done  = 1'b0;
            r_d.under = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req    = (r_q.st == ST_FETCH) || (r_q.st == ST_MOVE);
    assign mem_desc   = (r_q.st == ST_FETCH);
    assign mem_we     = (r_q.st == ST_MOVE) && r_q.we;
    assign mem_addr   = (r_q.st == ST_FETCH) ? r_q.ptr : r_q.cur_addr;
    assign mem_len    = (r_q.st == ST_FETCH) ? LEN_W'(DESC_BYTES) : r_q.seg;
    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign underrun   = r_q.under;
    assign guard_stop = r_q.guard;

endmodule

// File: rtl/prd_walk_chk.sv
module prd_walk_chk #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 17,
    parameter int DESC_BYTES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cancel,
    input logic              mem_req,
    input logic              mem_desc,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]  mem_len,
    input logic              mem_ack,
    input logic              busy,
    input logic              done,
    input logic              underrun
);

    // R2: a descriptor fetch is an 8-byte read
    a_r2_fetch_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_desc) |-> (mem_len == LEN_W'(DESC_BYTES) && !mem_we));

    // R3, R6: data segments are non-empty and even
    a_r3_even_segment: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_desc) |-> (mem_len != '0 && !mem_len[0]));

    // R10: an unacknowledged request holds still
    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cancel) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_len)
             && $stable(mem_desc) && $stable(mem_we)));

    // R11: cancel drops to idle with no result
    a_r11_cancel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cancel) |=> (!busy && !mem_req && !done && !underrun));

    // R12: a start while idle begins a walk
    a_r12_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R13: result pulses are exclusive, single-cycle and leave the walker idle
    a_r13_result_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && underrun));
    a_r13_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done || underrun) |-> !busy);
    a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done || underrun) |=> !(done || underrun));

endmodule

bind prd_walker prd_walk_chk #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .DESC_BYTES (DESC_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cancel   (cancel),
    .mem_req  (mem_req),
    .mem_desc (mem_desc),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_len  (mem_len),
    .mem_ack  (mem_ack),
    .busy     (busy),
    .done     (done),
    .underrun (underrun)
);

// File: tb/prd_walker_tb_top.sv
module prd_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cancel = 1'b0;
    logic        dir_to_host = 1'b0;
    logic [31:0] table_base = '0;
    logic [31:0] byte_limit = '0;
    logic        mem_req, mem_desc, mem_we;
    logic [31:0] mem_addr;
    logic [16:0] mem_len;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        busy, done, underrun, guard_stop;

    always #2.5 clk = ~clk;

    prd_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
        .dir_to_host(dir_to_host), .table_base(table_base), .byte_limit(byte_limit),
        .mem_req(mem_req), .mem_desc(mem_desc), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .underrun(underrun), .guard_stop(guard_stop)
    );

    typedef struct {
        bit          desc;
        bit          we;
        logic [31:0] addr;
        longint      len;
    } req_t;

    logic [63:0] dmem [int unsigned];
    req_t        expq[$];
    bit          exp_done;
    bit          exp_guard;
    int          n_checks = 0;
    int          n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] region,
                            input logic [31:0] ctl);
        dmem[at] = {ctl, region};
    endtask

    // behavioural prediction of the request stream and the outcome
    task automatic predict(input logic [31:0] base, input longint limit, input bit we);
        longint      need = limit;
        longint      left = 0;
        longint      seg;
        logic [31:0] ptr = base;
        logic [31:0] ca = 0;
        logic [63:0] w;
        bit          last = 0;
        expq.delete();
        forever begin
            if (need == 0 && left != 0) begin
                ca = ca + 32'(left);
                left = 0;
            end else if (need != 0 && left != 0) begin
                seg = (need < left) ? need : left;
                expq.push_back('{desc: 0, we: we, addr: ca, len: seg});
                ca = ca + 32'(seg);
                left -= seg;
                need -= seg;
            end else if (last || (ptr - base) >= 32'd4096) begin
                exp_done  = (need == 0);
                exp_guard = !last;
                break;
            end else begin
                expq.push_back('{desc: 1, we: 0, addr: ptr, len: 8});
                w = dmem.exists(ptr) ? dmem[ptr] : 64'd0;
                ca = w[31:0];
                left = longint'(w[47:32]) & 64'hFFFE;
                if (left == 0) left = 65536;
                last = w[63];
                ptr = ptr + 32'd8;
            end
        end
    endtask

    task automatic run(input string req, input logic [31:0] base, input longint limit,
                       input bit we, input int delay, input bit poke_start);
        int   waitc = 0;
        int   cyc = 0;
        bit   finished = 0;
        req_t e;
        predict(base, limit, we);
        @(negedge clk);
        table_base = base;
        byte_limit = 32'(limit);
        dir_to_host = we;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R12", "busy after start", longint'(busy), 1);
        while (!finished && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            mem_ack = 1'b0;
            start = 1'b0;
            if (poke_start && cyc == 3) start = 1'b1; // R12: start while busy ignored
            if (done || underrun) begin
                finished = 1;
            end else if (mem_req) begin
                if (expq.size() == 0) begin
                    chk(0, req, "unexpected request addr", longint'(mem_addr), 0);
                end else if (waitc < delay) begin
                    waitc++;
                end else begin
                    e = expq.pop_front();
                    chk(mem_desc === e.desc && mem_we === e.we && mem_addr === e.addr
                        && longint'(mem_len) == e.len, req,
                        mem_desc ? "fetch (addr<<20|len)" : "segment (addr<<20|len)",
                        (longint'(mem_addr) << 20) | longint'(mem_len),
                        (longint'(e.addr) << 20) | e.len);
                    chk(mem_we === e.we && mem_desc === e.desc, req, "kind/direction",
                        {mem_desc, mem_we}, {e.desc, e.we});
                    mem_ack = 1'b1;
                    if (mem_desc)
                        mem_rdata = dmem.exists(mem_addr) ? dmem[mem_addr] : 64'd0;
                    waitc = 0;
                end
            end
        end
        start = 1'b0;
        chk(finished, req, "watchdog: walk finished", finished, 1);
        chk(done === exp_done && underrun === !exp_done, exp_done ? "R7" : "R9",
            "result {done,underrun}", {done, underrun}, {exp_done, !exp_done});
        chk(guard_stop === exp_guard, "R8", "guard_stop", guard_stop, exp_guard);
        chk(busy === 1'b0, "R13", "busy at result", busy, 0);
        chk(expq.size() == 0, req, "requests left unissued", expq.size(), 0);
        @(negedge clk);
        chk(!done && !underrun, "R13", "result pulse width", {done, underrun}, 0);
        chk(guard_stop === exp_guard, "R8", "guard_stop held", guard_stop, exp_guard);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !mem_req && !done && !underrun && !guard_stop, "R1", "reset outputs",
            {busy, mem_req, done, underrun, guard_stop}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req, "R1", "idle after reset", {busy, mem_req}, 0);

        // R2 R4: single final descriptor, exact fit, reads from host
        put_desc(32'h0000_1000, 32'h0004_0000, 32'h8000_0200);
        run("R2", 32'h0000_1000, 512, 0, 0, 0);

        // R5 R6: split across three regions, extra bytes in the last one, to host
        put_desc(32'h0000_2000, 32'h0010_0000, 32'd300);
        put_desc(32'h0000_2008, 32'h0020_0000, 32'd400);
        put_desc(32'h0000_2010, 32'h0030_0000, 32'h8000_0258);
        run("R6", 32'h0000_2000, 1000, 1, 1, 0);

        // R3: odd length masked to even
        put_desc(32'h0000_3000, 32'h0050_0010, 32'h8000_0101);
        run("R3", 32'h0000_3000, 256, 1, 0, 0);

        // R3: zero length field means 65536 bytes
        put_desc(32'h0000_3100, 32'h0060_0000, 32'h0000_0000);
        put_desc(32'h0000_3108, 32'h0080_0000, 32'h8000_1F40);
        run("R3", 32'h0000_3100, 70000, 0, 2, 0);

        // R9: table too short
        put_desc(32'h0000_4000, 32'h0090_0000, 32'd500);
        put_desc(32'h0000_4008, 32'h00A0_0000, 32'h8000_01F4);
        run("R9", 32'h0000_4000, 2000, 0, 0, 0);

        // R7: surplus descriptors read but no data moved
        put_desc(32'h0000_5000, 32'h00B0_0000, 32'd100);
        put_desc(32'h0000_5008, 32'h00C0_0000, 32'd200);
        put_desc(32'h0000_5010, 32'h00D0_0000, 32'h8000_012C);
        run("R7", 32'h0000_5000, 100, 1, 0, 0);

        // R8: unterminated table stops after one page of descriptors
        for (int i = 0; i < 520; i++)
            put_desc(32'h0001_0000 + 32'(i * 8), 32'h0100_0000 + 32'(i * 16), 32'd2);
        run("R8", 32'h0001_0000, 64'h1000_0000, 0, 0, 0);
        run("R8", 32'h0001_0000, 4, 1, 0, 0);

        // R12: start pulse mid-walk must not restart it
        run("R12", 32'h0000_2000, 1000, 0, 1, 1);

        // R11: cancel while a fetch waits
        @(negedge clk);
        table_base = 32'h0000_2000;
        byte_limit = 32'd1000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!mem_req) @(negedge clk);
        cancel = 1'b1;
        @(negedge clk);
        cancel = 1'b0;
        chk(!busy && !mem_req && !done && !underrun, "R11", "cancel to idle",
            {busy, mem_req, done, underrun}, 0);
        repeat (5) @(negedge clk);
        chk(!busy && !done && !underrun, "R11", "quiet after cancel",
            {busy, done, underrun}, 0);

        // R2: new run reloads the pointer from the table base after cancel
        run("R2", 32'h0000_3000, 256, 0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule